// File: doc/BRIEF.md
# Display Controller Interrupt Status Unit

This block gathers the single-cycle event pulses produced by a display controller's descriptor fetch, FIFO and panel-timing logic. It holds them as sticky status flags and reduces them to one registered interrupt line. Each maskable source has its own mask bit. A mask bit stops the source from raising the interrupt, but the source's status flag is still recorded. The AC-bias-count source always interrupts.

The four frame-related sources are branch, start of frame, end of frame and bus error. When one of them arrives unmasked and no unmasked frame-related flag is still pending, the block captures the current frame identifier into a frame ID register. If another unmasked frame-related event arrives while the first is still pending, the block sets a separate subsequent-interrupt flag and keeps the earlier frame ID. Software reads the status, mask and frame ID registers through a simple register port. It clears flags by writing ones to the status register.

Top module: `disp_irq_status`

## Requirements
- R1: After a synchronous reset, every status flag, every mask bit, the frame ID register, `irq_o` and `reg_rdata_o` are zero.
- R2: The read address selects the register. Address 0 is status, address 1 is mask, address 2 is the frame ID zero-extended, and address 3 reads zero. `reg_rdata_o` shows the selected register as it stood before the clock edge that samples the address. Status bits 31:11 and bit 2 always read 0.
- R3: The status bit positions are: 10 subsequent, 9 branch, 8 end of frame, 7 quick disable, 6 output underrun, 5 upper input underrun, 4 lower input underrun, 3 AC bias count, 1 start of frame, 0 bus error. An event pulse sampled at a clock edge sets its flag at that edge, and the flag stays set until software clears it.
- R4: The branch flag sets only when `ev_branch_i` and `branch_irq_en_i` are both high. The end-of-frame flag sets only when `ev_eof_i` and `eof_irq_en_i` are both high.
- R5: The lower underrun flag sets only when `ev_lo_under_i` is high and `dual_panel_i` is 1. The upper underrun flag sets on `ev_up_under_i` in either panel mode.
- R6: A write to address 0 clears each status bit whose data bit is 1 and leaves the bits written as 0 unchanged. When an event and a clear hit the same bit in the same cycle, the bit stays set.
- R7: A write to address 1 loads mask bits 10:4, 1 and 0, where 1 means masked. Mask bits 3, 2 and 31:11 always read 0. A masked source still sets its status flag.
- R8: `irq_o` is registered and changes at the same edge as the flags. It is 1 exactly when some status flag is set whose mask bit is 0. The AC bias flag always counts.
- R9: An unmasked, qualified frame-related event (bits 9, 8, 1, 0) captures `frame_id_i` when no unmasked frame-related flag remains set after this cycle's clear. Masked frame events never capture.
- R10: If an unmasked, qualified frame-related event arrives while an unmasked frame-related flag remains set after this cycle's clear, the subsequent flag (bit 10) sets and the frame ID is kept.
- R11: Several unmasked frame-related events in the same cycle with none pending count as one first interrupt. They capture the frame ID and do not set the subsequent flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_branch_i | input | 1 | Branched-to descriptor loaded |
| branch_irq_en_i | input | 1 | Loaded descriptor requests a branch interrupt |
| ev_sof_i | input | 1 | Start of frame |
| ev_eof_i | input | 1 | Frame fetch finished |
| eof_irq_en_i | input | 1 | Finished frame's descriptor requests an end-of-frame interrupt |
| ev_bus_err_i | input | 1 | Bus error |
| ev_quick_dis_i | input | 1 | Controller quickly disabled |
| ev_out_under_i | input | 1 | Output FIFO underrun |
| ev_up_under_i | input | 1 | Upper or whole-panel input FIFO underrun |
| ev_lo_under_i | input | 1 | Lower-panel input FIFO underrun |
| dual_panel_i | input | 1 | 1 = dual-panel mode |
| ev_acbias_i | input | 1 | AC bias toggle count reached |
| frame_id_i | input | FID_W | Identifier of the current frame |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Flags, the frame ID and `irq_o` all change at the edge that samples the event or the write, so they are due one edge after the stimulus is driven. Read data is due one edge after the address is driven, and it holds the state from before that edge. The bench drives inputs on the falling edge and samples every output on the next falling edge. It updates a behavioural model at each rising edge and compares both outputs against that model every cycle. Directed reads are placed one full cycle after the writes or events they follow.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;
  localparam int unsigned NFLAG      = 11;
  localparam int unsigned BIT_SINT   = 10;
  localparam int unsigned BIT_BRANCH = 9;
  localparam int unsigned BIT_EOF    = 8;
  localparam int unsigned BIT_QDIS   = 7;
  localparam int unsigned BIT_OUND   = 6;
  localparam int unsigned BIT_UUND   = 5;
  localparam int unsigned BIT_LUND   = 4;
  localparam int unsigned BIT_ACB    = 3;
  localparam int unsigned BIT_SOF    = 1;
  localparam int unsigned BIT_BERR   = 0;

  typedef logic [NFLAG-1:0] flag_vec_t;

  // frame-related sources: branch, end of frame, start of frame, bus error
  localparam flag_vec_t FRAME_GRP = 11'b011_0000_0011;
  // bits software may mask (AC bias and bit 2 excluded)
  localparam flag_vec_t MASKABLE  = 11'b111_1111_0011;

  localparam int unsigned SEL_STATUS = 0;
  localparam int unsigned SEL_MASK   = 1;
  localparam int unsigned SEL_FID    = 2;
endpackage

// File: rtl/disp_irq_qual.sv
module disp_irq_qual
  import disp_irq_pkg::*;
(
  input  logic      ev_branch_i,
  input  logic      branch_irq_en_i,
  input  logic      ev_sof_i,
  input  logic      ev_eof_i,
  input  logic      eof_irq_en_i,
  input  logic      ev_bus_err_i,
  input  logic      ev_quick_dis_i,
  input  logic      ev_out_under_i,
  input  logic      ev_up_under_i,
  input  logic      ev_lo_under_i,
  input  logic      dual_panel_i,
  input  logic      ev_acbias_i,
  output flag_vec_t set_o
);
  always_comb begin
    set_o             = '0;
    set_o[BIT_BRANCH] = ev_branch_i & branch_irq_en_i;
    set_o[BIT_EOF]    = ev_eof_i & eof_irq_en_i;
    set_o[BIT_QDIS]   = ev_quick_dis_i;
    set_o[BIT_OUND]   = ev_out_under_i;
    set_o[BIT_UUND]   = ev_up_under_i;
    set_o[BIT_LUND]   = ev_lo_under_i & dual_panel_i;
    set_o[BIT_ACB]    = ev_acbias_i;
    set_o[BIT_SOF]    = ev_sof_i;
    set_o[BIT_BERR]   = ev_bus_err_i;
  end
endmodule

// File: rtl/disp_irq_flags.sv
module disp_irq_flags
  import disp_irq_pkg::*;
#(
  parameter int unsigned FID_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  flag_vec_t        set_i,
  input  flag_vec_t        clr_i,
  input  flag_vec_t        mask_i,
  input  logic [FID_W-1:0] frame_id_i,
  output flag_vec_t        status_q,
  output flag_vec_t        status_d,
  output logic [FID_W-1:0] fid_q
);
  flag_vec_t kept;
  logic      pend;
  logic      fr_hit;
  logic      sint_set;

  assign kept     = status_q & ~clr_i;
  assign pend     = |(kept & FRAME_GRP & ~mask_i);
  assign fr_hit   = |(set_i & FRAME_GRP & ~mask_i);
  assign sint_set = fr_hit & pend;

  for (genvar b = 0; b < NFLAG; b++) begin : g_flag
    if (b == BIT_SINT) begin : g_sint
      assign status_d[b] = kept[b] | set_i[b] | sint_set;
    end else if (b == 2) begin : g_rsvd
      assign status_d[b] = 1'b0;
    end else begin : g_src
      assign status_d[b] = kept[b] | set_i[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      fid_q    <= '0;
    end else begin
      status_q <= status_d;
      if (fr_hit && !pend) fid_q <= frame_id_i;
    end
  end
endmodule

// File: rtl/disp_irq_regs.sv
module disp_irq_regs
  import disp_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned FID_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  flag_vec_t         status_q_i,
  input  logic [FID_W-1:0]  fid_q_i,
  output flag_vec_t         clr_o,
  output flag_vec_t         mask_q,
  output flag_vec_t         mask_d,
  output logic [DATA_W-1:0] rdata_q
);
  localparam int unsigned PAD_F = DATA_W - NFLAG;
  localparam int unsigned PAD_I = DATA_W - FID_W;

  logic              sel_status;
  logic              sel_mask;
  logic              sel_fid;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_hi;

  assign sel_status = (addr_i == ADDR_W'(SEL_STATUS));
  assign sel_mask   = (addr_i == ADDR_W'(SEL_MASK));
  assign sel_fid    = (addr_i == ADDR_W'(SEL_FID));
  assign unused_hi  = ^wdata_i[DATA_W-1:NFLAG];

  assign clr_o  = (wr_i && sel_status) ? wdata_i[NFLAG-1:0] : '0;
  assign mask_d = (wr_i && sel_mask) ? (wdata_i[NFLAG-1:0] & MASKABLE) : mask_q;

  always_comb begin
    rd_mux = '0;
    if (sel_status)    rd_mux = {{PAD_F{1'b0}}, status_q_i};
    else if (sel_mask) rd_mux = {{PAD_F{1'b0}}, mask_q};
    else if (sel_fid)  rd_mux = {{PAD_I{1'b0}}, fid_q_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      rdata_q <= '0;
    end else begin
      mask_q  <= mask_d;
      rdata_q <= rd_mux;
    end
  end
endmodule

// File: rtl/disp_irq_status.sv
module disp_irq_status
  import disp_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned FID_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_branch_i,
  input  logic              branch_irq_en_i,
  input  logic              ev_sof_i,
  input  logic              ev_eof_i,
  input  logic              eof_irq_en_i,
  input  logic              ev_bus_err_i,
  input  logic              ev_quick_dis_i,
  input  logic              ev_out_under_i,
  input  logic              ev_up_under_i,
  input  logic              ev_lo_under_i,
  input  logic              dual_panel_i,
  input  logic              ev_acbias_i,
  input  logic [FID_W-1:0]  frame_id_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  flag_vec_t        set_vec;
  flag_vec_t        clr_vec;
  flag_vec_t        mask_q;
  flag_vec_t        mask_d;
  flag_vec_t        status_q;
  flag_vec_t        status_d;
  logic [FID_W-1:0] fid_q;
  logic             irq_q;

  disp_irq_qual u_qual (
    .ev_branch_i     (ev_branch_i),
    .branch_irq_en_i (branch_irq_en_i),
    .ev_sof_i        (ev_sof_i),
    .ev_eof_i        (ev_eof_i),
    .eof_irq_en_i    (eof_irq_en_i),
    .ev_bus_err_i    (ev_bus_err_i),
    .ev_quick_dis_i  (ev_quick_dis_i),
    .ev_out_under_i  (ev_out_under_i),
    .ev_up_under_i   (ev_up_under_i),
    .ev_lo_under_i   (ev_lo_under_i),
    .dual_panel_i    (dual_panel_i),
    .ev_acbias_i     (ev_acbias_i),
    .set_o           (set_vec)
  );

  disp_irq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FID_W(FID_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .status_q_i (status_q),
    .fid_q_i    (fid_q),
    .clr_o      (clr_vec),
    .mask_q     (mask_q),
    .mask_d     (mask_d),
    .rdata_q    (reg_rdata_o)
  );

  disp_irq_flags #(.FID_W(FID_W)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .set_i      (set_vec),
    .clr_i      (clr_vec),
    .mask_i     (mask_q),
    .frame_id_i (frame_id_i),
    .status_q   (status_q),
    .status_d   (status_d),
    .fid_q      (fid_q)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(status_d & ~mask_d);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/disp_irq_status_chk.sv
module disp_irq_status_chk
  import disp_irq_pkg::*;
#(
  parameter int unsigned FID_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ev_quick_dis_i,
  input logic             ev_acbias_i,
  input logic             ev_lo_under_i,
  input logic             dual_panel_i,
  input flag_vec_t        clr_vec,
  input flag_vec_t        status,
  input flag_vec_t        mask,
  input logic [FID_W-1:0] fid,
  input logic             irq_o
);
  logic pend_now;
  assign pend_now = |(status & FRAME_GRP & ~mask);

  AST_QD_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
    ev_quick_dis_i |=> status[BIT_QDIS]);                                  // R3
  AST_LO_NEEDS_DUAL: assert property (@(posedge clk) disable iff (rst)
    (!(ev_lo_under_i && dual_panel_i) && !status[BIT_LUND]) |=> !status[BIT_LUND]); // R5
  AST_QD_W1C: assert property (@(posedge clk) disable iff (rst)
    (clr_vec[BIT_QDIS] && !ev_quick_dis_i) |=> !status[BIT_QDIS]);         // R6
  AST_MASK_FIXED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (mask[BIT_ACB] == 1'b0) && (mask[2] == 1'b0));                          // R7
  AST_ACB_ALWAYS_IRQ: assert property (@(posedge clk) disable iff (rst)
    ev_acbias_i |=> irq_o);                                                 // R8
  AST_FID_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (pend_now && (clr_vec == '0)) |=> $stable(fid));                        // R10
endmodule

bind disp_irq_status disp_irq_status_chk #(.FID_W(FID_W)) i_chk (
  .clk            (clk),
  .rst            (rst),
  .ev_quick_dis_i (ev_quick_dis_i),
  .ev_acbias_i    (ev_acbias_i),
  .ev_lo_under_i  (ev_lo_under_i),
  .dual_panel_i   (dual_panel_i),
  .clr_vec        (clr_vec),
  .status         (status_q),
  .mask           (mask_q),
  .fid            (fid_q),
  .irq_o          (irq_o)
);

// File: tb/test_disp_irq_status.sv
`timescale 1ns/1ps
module test_disp_irq_status;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;
  localparam int FID_W  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_branch = 0, br_en = 0, ev_sof = 0, ev_eof = 0, eof_en = 0, ev_berr = 0;
  logic ev_qd = 0, ev_ou = 0, ev_uu = 0, ev_lu = 0, dual = 0, ev_acb = 0;
  logic [FID_W-1:0]  fid_in = '0;
  logic              wr = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  disp_irq_status #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FID_W(FID_W)) i_disp_irq_status (
    .clk(clk), .rst(rst),
    .ev_branch_i(ev_branch), .branch_irq_en_i(br_en), .ev_sof_i(ev_sof),
    .ev_eof_i(ev_eof), .eof_irq_en_i(eof_en), .ev_bus_err_i(ev_berr),
    .ev_quick_dis_i(ev_qd), .ev_out_under_i(ev_ou), .ev_up_under_i(ev_uu),
    .ev_lo_under_i(ev_lu), .dual_panel_i(dual), .ev_acbias_i(ev_acb),
    .frame_id_i(fid_in), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference model
  int unsigned m_stat = 0, m_mask = 0, m_fid = 0, m_rdata = 0;
  bit          m_irq = 0;

  always @(posedge clk) begin
    int unsigned ev, clr, left, frm;
    bit pending, hit;
    if (rst) begin
      m_stat = 0; m_mask = 0; m_fid = 0; m_rdata = 0; m_irq = 0;
    end else begin
      ev = 0;
      if (ev_berr)            ev = ev | (1 << 0);
      if (ev_sof)             ev = ev | (1 << 1);
      if (ev_acb)             ev = ev | (1 << 3);
      if (ev_lu && dual)      ev = ev | (1 << 4);
      if (ev_uu)              ev = ev | (1 << 5);
      if (ev_ou)              ev = ev | (1 << 6);
      if (ev_qd)              ev = ev | (1 << 7);
      if (ev_eof && eof_en)   ev = ev | (1 << 8);
      if (ev_branch && br_en) ev = ev | (1 << 9);
      case (addr)
        2'd0:    m_rdata = m_stat;
        2'd1:    m_rdata = m_mask;
        2'd2:    m_rdata = m_fid;
        default: m_rdata = 0;
      endcase
      clr = (wr && addr == 2'd0) ? (wdata & 32'h7FF) : 0;
      left = m_stat & ~clr;
      pending = 0; hit = 0;
      foreach (frm_bits[i]) begin
        frm = frm_bits[i];
        if (((left >> frm) & 1) != 0 && ((m_mask >> frm) & 1) == 0) pending = 1;
        if (((ev >> frm) & 1) != 0 && ((m_mask >> frm) & 1) == 0) hit = 1;
      end
      m_stat = left | ev;
      if (hit && pending) m_stat = m_stat | (1 << 10);
      if (hit && !pending) m_fid = fid_in;
      if (wr && addr == 2'd1) m_mask = wdata & 32'h7F3;
      m_irq = (m_stat & ~m_mask) != 0;
    end
  end
  int unsigned frm_bits [4] = '{0, 1, 8, 9};

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (irq !== m_irq) begin
        failures++;
        $display("FAIL R8 irq_o act=%0d exp=%0d at %0t", irq, m_irq, $time);
      end
      checks++;
      if (rdata !== m_rdata) begin
        failures++;
        $display("FAIL R2 reg_rdata_o act=%0h exp=%0h at %0t", rdata, m_rdata, $time);
      end
    end
  end

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    wr = 1; addr = a; wdata = d;
    step();
    wr = 0; wdata = '0;
  endtask

  task automatic reg_read(logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    addr = a;
    step();
    d = rdata;
  endtask

  task automatic clear_all_events();
    ev_branch = 0; ev_sof = 0; ev_eof = 0; ev_berr = 0; ev_qd = 0;
    ev_ou = 0; ev_uu = 0; ev_lu = 0; ev_acb = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      done = 1;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] v;
    @(negedge clk); @(negedge clk);
    rst = 0;
    @(negedge clk);
    // r1_ reset state
    reg_read(2'd0, v); check("R1 status after reset", v, 0);
    reg_read(2'd1, v); check("R1 mask after reset", v, 0);
    reg_read(2'd2, v); check("R1 frame id after reset", v, 0);
    check("R1 irq after reset", {31'b0, irq}, 0);

    // R3 quick-disable event, sticky flag
    ev_qd = 1; step(); ev_qd = 0;
    check("R8 irq after quick disable", {31'b0, irq}, 1);
    step(); step();
    reg_read(2'd0, v); check("R3 quick-disable flag sticky", v, 32'h80);

    // R6 write zero ignored, write one clears
    reg_write(2'd0, 32'h0);
    reg_read(2'd0, v); check("R6 write zero keeps flag", v, 32'h80);
    reg_write(2'd0, 32'h80);
    reg_read(2'd0, v); check("R6 write one clears flag", v, 0);
    check("R8 irq drops after clear", {31'b0, irq}, 0);

    // R4 qualification
    ev_branch = 1; br_en = 0; ev_eof = 1; eof_en = 0; step(); clear_all_events();
    reg_read(2'd0, v); check("R4 unqualified branch and eof ignored", v, 0);
    ev_eof = 1; eof_en = 1; fid_in = 16'h0011; step(); clear_all_events(); eof_en = 0;
    reg_read(2'd0, v); check("R4 qualified eof sets bit 8", v, 32'h100);
    reg_read(2'd2, v); check("R9 first frame irq captures id", v, 32'h11);

    // R10 subsequent interrupt
    ev_sof = 1; fid_in = 16'h0022; step(); clear_all_events();
    reg_read(2'd0, v); check("R10 subsequent flag set", v, 32'h502);
    reg_read(2'd2, v); check("R10 frame id kept", v, 32'h11);
    reg_write(2'd0, 32'h502);

    // R5 lower panel gating
    ev_lu = 1; dual = 0; step(); clear_all_events();
    reg_read(2'd0, v); check("R5 lower underrun ignored single panel", v, 0);
    ev_uu = 1; ev_lu = 1; dual = 1; step(); clear_all_events();
    reg_read(2'd0, v); check("R5 both underruns in dual panel", v, 32'h30);
    reg_write(2'd0, 32'h30); dual = 0;

    // R7 masking
    reg_write(2'd1, 32'hFFFF_FFFF);
    reg_read(2'd1, v); check("R7 mask writable bits only", v, 32'h7F3);
    ev_ou = 1; step(); clear_all_events();
    check("R7 masked source no irq", {31'b0, irq}, 0);
    reg_read(2'd0, v); check("R7 masked source still flags", v, 32'h40);
    ev_acb = 1; step(); clear_all_events();
    check("R8 AC bias unmaskable", {31'b0, irq}, 1);
    reg_write(2'd0, 32'h7FF);
    ev_eof = 1; eof_en = 1; fid_in = 16'h0033; step(); clear_all_events(); eof_en = 0;
    reg_read(2'd2, v); check("R9 masked frame event no capture", v, 32'h11);
    reg_write(2'd0, 32'h7FF);
    reg_write(2'd1, 32'h0);

    // R6 event beats clear in same cycle
    ev_qd = 1; step();
    wr = 1; addr = 2'd0; wdata = 32'h80; step();
    wr = 0; wdata = 0; clear_all_events();
    reg_read(2'd0, v); check("R6 event wins over clear", v, 32'h80);
    reg_write(2'd0, 32'h80);

    // R11 simultaneous first events
    ev_sof = 1; ev_berr = 1; fid_in = 16'h0044; step(); clear_all_events();
    reg_read(2'd0, v); check("R11 simultaneous events no subsequent", v, 32'h3);
    reg_read(2'd2, v); check("R11 simultaneous events capture", v, 32'h44);

    // R9 clear of only pending flag together with new event
    wr = 1; addr = 2'd0; wdata = 32'h3; ev_eof = 1; eof_en = 1; fid_in = 16'h0055;
    step(); wr = 0; wdata = 0; clear_all_events(); eof_en = 0;
    reg_read(2'd0, v); check("R9 cleared pending counts as first", v, 32'h100);
    reg_read(2'd2, v); check("R9 recapture after clear", v, 32'h55);
    reg_read(2'd3, v); check("R2 address 3 reads zero", v, 0);

    // random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      ev_branch = ($urandom % 5) == 0; br_en = $urandom % 2;
      ev_sof = ($urandom % 6) == 0; ev_eof = ($urandom % 6) == 0; eof_en = $urandom % 2;
      ev_berr = ($urandom % 9) == 0; ev_qd = ($urandom % 9) == 0;
      ev_ou = ($urandom % 9) == 0; ev_uu = ($urandom % 9) == 0;
      ev_lu = ($urandom % 7) == 0; dual = $urandom % 2; ev_acb = ($urandom % 15) == 0;
      fid_in = FID_W'($urandom);
      wr = ($urandom % 3) == 0; addr = ADDR_W'($urandom);
      wdata = (addr == 2'd1) ? (($urandom % 2) ? $urandom : 0) : $urandom;
      step();
    end
    clear_all_events(); wr = 0;
    step();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule